// File: doc/BRIEF.md
# DRAM Strobe Mode Decoder

This block is the device-side control of an asynchronous page-mode DRAM, rebuilt as synchronous logic on a fast sampling clock. It watches the four active-low strobes (row strobe, column strobe, write enable, output enable). From the order of their edges it decides what each memory cycle is: standby, read, early or late write, read-modify-write, RAS-only refresh, CAS-before-RAS refresh, or hidden refresh. It then drives the controls an array needs. These are a one-cycle row-open pulse with the row to open, a one-cycle column-latch pulse with the column, a one-cycle write pulse with the captured input byte, and the data-output enable.

All strobes go through a two-flop synchroniser. The address and data inputs are delayed by the same number of stages so that they stay aligned with the strobes. Edges are found by comparing successive synchronised samples. Every output is registered. A level change on the pins therefore appears on the outputs at the third rising clock edge after it is first sampled. A 10-bit counter supplies the row for self-addressed refresh cycles. The array, its sense path and the analog timing checks are outside the block. The strobes are level signals with no flow control, so the block has no valid/ready handshake. A write pulse is a single-cycle command that the array must accept in that cycle.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While reset is low, and after it is released, every output is zero and the refresh counter is zero. A reset in the middle of a cycle returns the block to standby.
- R2: When the row strobe falls while the column strobe is high, the block pulses `row_stb` for one cycle. It loads `row_addr` with the external address and reports the cycle kind as RAS-only refresh (code 5). If the column strobe never falls, no column, write or output activity follows.
- R3: When the column strobe falls in an open row, the block pulses `col_stb`. It loads `col_addr` with the low `COL_W` address bits. The kind becomes read (code 1) if write enable is high. If write enable is already low, the kind becomes write (code 2) and an early write takes place.
- R4: `dout_en` is high only during a column access in which the column strobe and output enable are low and write enable is high. A read therefore starts at whichever of the column strobe and output enable falls later.
- R5: When write enable falls during a column access that began as a read, the block pulses `wr_stb` and captures `din` into `wr_data`. The kind is read-modify-write (code 3) if data was driven earlier in that access, and write (code 2) otherwise.
- R6: When the column strobe is already low as the row strobe falls, the cycle is a CAS-before-RAS refresh (code 6). `row_addr` takes the counter value and the external address is ignored. The counter then advances by one.
- R7: During a CAS-before-RAS refresh, `dout_en`, `wr_stb` and `col_stb` stay low, whatever write enable and output enable do.
- R8: The row strobe may rise and fall again while the column strobe is held low after a column access. This is a hidden refresh (code 4): it opens the counter's row, advances the counter and keeps `dout_en` on.
- R9: Any cycle ends only when both the row and column strobes are high. The kind then returns to standby (code 0) and `dout_en` goes low.
- R10: The refresh counter wraps from 1023 to 0.
- R11: Outputs respond at the third rising clock edge after a pin change is first sampled.
- R12: If the column strobe rises while the row strobe stays low, the row stays open. The next column-strobe fall latches a new column without a new `row_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W (10) | Multiplexed row/column address |
| din | input | DATA_W (8) | Write data from the pins |
| row_stb | output | 1 | One-cycle row-open pulse |
| row_addr | output | ROW_W (10) | Row to open (external or counter) |
| col_stb | output | 1 | One-cycle column-latch pulse |
| col_addr | output | COL_W (9) | Latched column |
| wr_stb | output | 1 | One-cycle write pulse to the array |
| wr_data | output | DATA_W (8) | Byte captured at the write start |
| dout_en | output | 1 | Drive read data onto the pins |
| cycle_kind | output | 3 | 0 standby, 1 read, 2 write, 3 read-modify-write, 4 hidden refresh, 5 RAS-only refresh, 6 CAS-before-RAS refresh |

## Verification
The hardest situation to reach is a hidden refresh. It needs a column access that is already driving data, then the row strobe rising and falling again while the column strobe never leaves low. The stimulus table builds this in order: it opens a row, drops the column strobe and output enable together, raises the row strobe alone, then drops it again. The counter wrap is the other deep state. A directed loop issues 1025 CAS-before-RAS cycles after a reset and checks the supplied row on every one.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;
  // bit positions of the strobe vector {ras, cas, we, oe}
  localparam int STB_RAS = 3;
  localparam int STB_CAS = 2;
  localparam int STB_WE  = 1;
  localparam int STB_OE  = 0;
  localparam int STB_W   = 4;

  typedef enum logic [2:0] {
    K_STANDBY  = 3'd0,
    K_READ     = 3'd1,
    K_WRITE    = 3'd2,
    K_RMW      = 3'd3,
    K_HIDDEN   = 3'd4,
    K_RAS_ONLY = 3'd5,
    K_CBR      = 3'd6
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,   // both strobes high
    ST_ROW,    // row open, column strobe high
    ST_COL,    // row and column strobes low
    ST_HOLD,   // row strobe back high, column strobe still low
    ST_HID,    // hidden refresh in progress
    ST_CBR     // column-before-row refresh in progress
  } state_e;
endpackage

// File: rtl/dsm_pipe.sv
`timescale 1ns/1ps
module dsm_pipe #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsm_edge.sv
`timescale 1ns/1ps
module dsm_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_fall
    assign fall[i] = prev[i] & ~cur[i];
  end
endmodule

// File: rtl/dsm_refresh_ctr.sv
`timescale 1ns/1ps
module dsm_refresh_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;  // natural wrap at the top
  end
endmodule

// File: rtl/dsm_ctrl.sv
`timescale 1ns/1ps
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STB_W-1:0]  s_lvl,
  input  logic              f_ras,
  input  logic              f_cas,
  input  logic              f_we,
  input  logic [ROW_W-1:0]  a_al,
  input  logic [DATA_W-1:0] d_al,
  input  logic [ROW_W-1:0]  ctr_row,
  output logic              ctr_adv,
  output logic              row_stb,
  output logic [ROW_W-1:0]  row_addr,
  output logic              col_stb,
  output logic [COL_W-1:0]  col_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout_en,
  output logic [2:0]        kind
);
  state_e st_q, st_n;
  kind_e  kind_q, kind_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic rstb_n, cstb_n, wstb_n, dout_n, rd_q, rd_n;

  logic s_ras, s_cas, s_we, s_oe, both_high, access_n;
  assign s_ras     = s_lvl[STB_RAS];
  assign s_cas     = s_lvl[STB_CAS];
  assign s_we      = s_lvl[STB_WE];
  assign s_oe      = s_lvl[STB_OE];
  assign both_high = s_ras & s_cas;

  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    row_n   = row_q;
    col_n   = col_q;
    wd_n    = wd_q;
    rd_n    = rd_q;
    rstb_n  = 1'b0;
    cstb_n  = 1'b0;
    wstb_n  = 1'b0;
    ctr_adv = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (f_ras) begin
          rstb_n = 1'b1;
          rd_n   = 1'b0;
          if (!s_cas) begin            // column already low: self-addressed refresh
            st_n    = ST_CBR;
            row_n   = ctr_row;
            ctr_adv = 1'b1;
            kind_n  = K_CBR;
          end else begin
            st_n   = ST_ROW;
            row_n  = a_al;
            kind_n = K_RAS_ONLY;
          end
        end
      end
      ST_ROW: begin
        if (s_ras) begin
          if (s_cas) begin
            st_n   = ST_IDLE;
            kind_n = K_STANDBY;
          end
        end else if (f_cas) begin
          st_n   = ST_COL;
          cstb_n = 1'b1;
          col_n  = a_al[COL_W-1:0];
          if (!s_we) begin             // early write
            wstb_n = 1'b1;
            wd_n   = d_al;
            kind_n = K_WRITE;
          end else begin
            kind_n = K_READ;
          end
        end
      end
      ST_COL: begin
        if (both_high) begin
          st_n   = ST_IDLE;
          kind_n = K_STANDBY;
        end else if (s_ras) begin
          st_n = ST_HOLD;
        end else if (s_cas) begin
          st_n = ST_ROW;               // page mode: row stays open
        end else begin
          if (!s_oe && s_we) rd_n = 1'b1;
          if (f_we && kind_q == K_READ) begin
            wstb_n = 1'b1;
            wd_n   = d_al;
            kind_n = rd_q ? K_RMW : K_WRITE;
          end
        end
      end
      ST_HOLD: begin
        if (s_cas) begin
          st_n   = ST_IDLE;
          kind_n = K_STANDBY;
        end else if (f_ras) begin
          st_n    = ST_HID;
          rstb_n  = 1'b1;
          row_n   = ctr_row;
          ctr_adv = 1'b1;
          kind_n  = K_HIDDEN;
        end
      end
      ST_HID, ST_CBR: begin
        if (both_high) begin
          st_n   = ST_IDLE;
          kind_n = K_STANDBY;
        end
      end
      default: begin
        st_n   = ST_IDLE;
        kind_n = K_STANDBY;
      end
    endcase
    access_n = (st_n == ST_COL) || (st_n == ST_HOLD) || (st_n == ST_HID);
    dout_n   = access_n && !s_cas && !s_oe && s_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_STANDBY;
      row_q   <= '0;
      col_q   <= '0;
      wd_q    <= '0;
      rd_q    <= 1'b0;
      row_stb <= 1'b0;
      col_stb <= 1'b0;
      wr_stb  <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      st_q    <= st_n;
      kind_q  <= kind_n;
      row_q   <= row_n;
      col_q   <= col_n;
      wd_q    <= wd_n;
      rd_q    <= rd_n;
      row_stb <= rstb_n;
      col_stb <= cstb_n;
      wr_stb  <= wstb_n;
      dout_en <= dout_n;
    end
  end

  assign row_addr = row_q;
  assign col_addr = col_q;
  assign wr_data  = wd_q;
  assign kind     = kind_q;
endmodule

// File: rtl/dram_strobe_ctrl.sv
`timescale 1ns/1ps
module dram_strobe_ctrl
  import dsm_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic              row_stb,
  output logic [ROW_W-1:0]  row_addr,
  output logic              col_stb,
  output logic [COL_W-1:0]  col_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout_en,
  output logic [2:0]        cycle_kind
);
  localparam int EDGE_W = 3;  // row, column and write strobes need edges

  logic [STB_W-1:0]  strb_raw, strb_s;
  logic [ROW_W-1:0]  addr_al;
  logic [DATA_W-1:0] din_al;
  logic [EDGE_W-1:0] falls;
  logic [ROW_W-1:0]  ref_row;
  logic              ref_adv;

  assign strb_raw = {ras_n, cas_n, we_n, oe_n};

  dsm_pipe #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s));

  dsm_pipe #(.W(ROW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_al (
    .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_al));

  dsm_pipe #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_al (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_al));

  dsm_edge #(.W(EDGE_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(strb_s[STB_W-1:STB_WE]), .fall(falls));

  dsm_refresh_ctr #(.W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(ref_adv), .row(ref_row));

  dsm_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_lvl(strb_s),
    .f_ras(falls[2]), .f_cas(falls[1]), .f_we(falls[0]),
    .a_al(addr_al), .d_al(din_al),
    .ctr_row(ref_row), .ctr_adv(ref_adv),
    .row_stb(row_stb), .row_addr(row_addr),
    .col_stb(col_stb), .col_addr(col_addr),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .dout_en(dout_en), .kind(cycle_kind));
endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_stb,
  input logic [ROW_W-1:0] row_addr,
  input logic             col_stb,
  input logic             wr_stb,
  input logic             dout_en,
  input logic [2:0]       kind,
  input logic [ROW_W-1:0] ctr
);
  assert_row_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> !row_stb);

  assert_col_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |-> (kind == 3'd1 || kind == 3'd2));

  assert_wr_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (kind == 3'd2 || kind == 3'd3));

  assert_refresh_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd6) |-> (!dout_en && !wr_stb && !col_stb));

  assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd0) |-> (!dout_en && !col_stb && !wr_stb));

  assert_ctr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && (kind == 3'd6 || kind == 3'd4)) |=> (ctr == ROW_W'($past(row_addr) + 1'b1)));
endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .row_addr(row_addr),
  .col_stb(col_stb), .wr_stb(wr_stb), .dout_en(dout_en),
  .kind(cycle_kind), .ctr(ref_row));

// File: tb/dram_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_tb_top;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 9;
  localparam int DATA_W = 8;
  localparam int NV     = 29;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ras_n, cas_n, we_n, oe_n;
  logic [ROW_W-1:0]  addr;
  logic [DATA_W-1:0] din;
  logic row_stb, col_stb, wr_stb, dout_en;
  logic [ROW_W-1:0]  row_addr;
  logic [COL_W-1:0]  col_addr;
  logic [DATA_W-1:0] wr_data;
  logic [2:0]        cycle_kind;

  int n_chk = 0;
  int n_err = 0;

  dram_strobe_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .row_stb(row_stb), .row_addr(row_addr),
    .col_stb(col_stb), .col_addr(col_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .dout_en(dout_en), .cycle_kind(cycle_kind));

  // {strobes ras,cas,we,oe | addr | din | row_stb row_addr | col_stb col_addr | wr_stb wr_data | dout_en | kind}
  localparam logic [55:0] VEC [NV] = '{
    {4'b1111,10'h000,8'h00, 1'b0,10'h000, 1'b0,9'h000, 1'b0,8'h00, 1'b0,3'd0}, // idle
    {4'b0111,10'h155,8'h00, 1'b1,10'h155, 1'b0,9'h000, 1'b0,8'h00, 1'b0,3'd5}, // R2 row open
    {4'b0011,10'h0AA,8'h00, 1'b0,10'h155, 1'b1,9'h0AA, 1'b0,8'h00, 1'b0,3'd1}, // R3 read column
    {4'b0010,10'h0AA,8'h00, 1'b0,10'h155, 1'b0,9'h0AA, 1'b0,8'h00, 1'b1,3'd1}, // R4 oe last
    {4'b0000,10'h0AA,8'h5A, 1'b0,10'h155, 1'b0,9'h0AA, 1'b1,8'h5A, 1'b0,3'd3}, // R5 rmw
    {4'b1111,10'h000,8'h00, 1'b0,10'h155, 1'b0,9'h0AA, 1'b0,8'h5A, 1'b0,3'd0}, // R9 end
    {4'b0111,10'h3FF,8'h00, 1'b1,10'h3FF, 1'b0,9'h0AA, 1'b0,8'h5A, 1'b0,3'd5}, // R2
    {4'b0001,10'h012,8'hC3, 1'b0,10'h3FF, 1'b1,9'h012, 1'b1,8'hC3, 1'b0,3'd2}, // R3 early write
    {4'b0101,10'h012,8'hC3, 1'b0,10'h3FF, 1'b0,9'h012, 1'b0,8'hC3, 1'b0,3'd2}, // R12 cas up
    {4'b0011,10'h1F0,8'h00, 1'b0,10'h3FF, 1'b1,9'h1F0, 1'b0,8'hC3, 1'b0,3'd1}, // R12 new column
    {4'b1111,10'h000,8'h00, 1'b0,10'h3FF, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd0}, // R9
    {4'b0111,10'h200,8'h00, 1'b1,10'h200, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd5}, // R2 ras-only
    {4'b1111,10'h200,8'h00, 1'b0,10'h200, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd0}, // R2 ends quiet
    {4'b1011,10'h2AB,8'h00, 1'b0,10'h200, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd0}, // cas first
    {4'b0011,10'h2AB,8'h00, 1'b1,10'h000, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd6}, // R6 addr ignored
    {4'b0000,10'h2AB,8'h99, 1'b0,10'h000, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd6}, // R7 no io
    {4'b1111,10'h000,8'h00, 1'b0,10'h000, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd0}, // R9
    {4'b1011,10'h000,8'h00, 1'b0,10'h000, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd0},
    {4'b0011,10'h155,8'h00, 1'b1,10'h001, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd6}, // R6 advanced
    {4'b1111,10'h000,8'h00, 1'b0,10'h001, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd0},
    {4'b0111,10'h011,8'h00, 1'b1,10'h011, 1'b0,9'h1F0, 1'b0,8'hC3, 1'b0,3'd5},
    {4'b0011,10'h022,8'h00, 1'b0,10'h011, 1'b1,9'h022, 1'b0,8'hC3, 1'b0,3'd1},
    {4'b0001,10'h022,8'h7E, 1'b0,10'h011, 1'b0,9'h022, 1'b1,8'h7E, 1'b0,3'd2}, // R5 late write
    {4'b1111,10'h000,8'h00, 1'b0,10'h011, 1'b0,9'h022, 1'b0,8'h7E, 1'b0,3'd0},
    {4'b0111,10'h0C0,8'h00, 1'b1,10'h0C0, 1'b0,9'h022, 1'b0,8'h7E, 1'b0,3'd5},
    {4'b0010,10'h033,8'h00, 1'b0,10'h0C0, 1'b1,9'h033, 1'b0,8'h7E, 1'b1,3'd1}, // R4 together
    {4'b1010,10'h033,8'h00, 1'b0,10'h0C0, 1'b0,9'h033, 1'b0,8'h7E, 1'b1,3'd1}, // R8 ras up
    {4'b0010,10'h033,8'h00, 1'b1,10'h002, 1'b0,9'h033, 1'b0,8'h7E, 1'b1,3'd4}, // R8 hidden
    {4'b1111,10'h000,8'h00, 1'b0,10'h002, 1'b0,9'h033, 1'b0,8'h7E, 1'b0,3'd0}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample after the third rising edge (R11)
  task automatic step(input logic [3:0] s, input logic [ROW_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    {ras_n, cas_n, we_n, oe_n} = s;
    addr = a;
    din  = d;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " row_stb"},  32'(row_stb),    0);
    chk({tag, " row_addr"}, 32'(row_addr),   0);
    chk({tag, " col_stb"},  32'(col_stb),    0);
    chk({tag, " wr_stb"},   32'(wr_stb),     0);
    chk({tag, " dout_en"},  32'(dout_en),    0);
    chk({tag, " kind"},     32'(cycle_kind), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ras_n, cas_n, we_n, oe_n} = 4'b1111;
    addr = '0;
    din  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_zero("R1 reset");
    chk("R1 reset col_addr", 32'(col_addr), 0);
    chk("R1 reset wr_data",  32'(wr_data),  0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      step(v[55:52], v[51:42], v[41:34]);
      chk($sformatf("row %0d R2 R6 R8 row_stb", i),  32'(row_stb),    32'(v[33]));
      chk($sformatf("row %0d R2 R6 R8 row_addr", i), 32'(row_addr),   32'(v[32:23]));
      chk($sformatf("row %0d R3 R12 col", i),        32'({col_stb, col_addr}), 32'(v[22:13]));
      chk($sformatf("row %0d R5 R7 write", i),       32'({wr_stb, wr_data}),   32'(v[12:4]));
      chk($sformatf("row %0d R4 R7 dout_en", i),     32'(dout_en),    32'(v[3]));
      chk($sformatf("row %0d R3 R9 kind", i),        32'(cycle_kind), 32'(v[2:0]));
    end

    // R6: counter continues at 3 after the table
    step(4'b1011, 10'h000, 8'h00);
    step(4'b0011, 10'h3C3, 8'h00);
    chk("R6 counter continues", 32'(row_addr), 32'h003);

    // R1: reset in the middle of a refresh cycle
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_zero("R1 mid-cycle reset");
    {ras_n, cas_n, we_n, oe_n} = 4'b1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: counter starts at zero after reset and wraps 1023 -> 0
    for (int i = 0; i <= 1024; i++) begin
      step(4'b1011, 10'h155, 8'h00);
      step(4'b0011, 10'h155, 8'h00);
      chk($sformatf("R10 cbr %0d row_stb", i), 32'(row_stb), 1);
      chk($sformatf("R10 cbr %0d row", i), 32'(row_addr), 32'(i % 1024));
      step(4'b1111, 10'h000, 8'h00);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule